// File: doc/BRIEF.md
# Latching Low-Voltage Load Disconnect

This block decides whether the load on a battery pack stays energised. It watches a pack voltage code (in millivolts) and a state-of-charge percentage, both delivered together with a one-cycle sample strobe. When a sample shows the pack sagging below the disconnect level, the relay drive drops on the next clock. The block then latches in a tripped state.

A voltage recovery alone never ends the tripped state. The load returns only when one strobed sample shows both of these at once: the voltage is above a reconnect level set well above the disconnect level, and the charge figure is above a minimum. In practice this means a charger has put real energy back into the pack. A brief bounce after a heavy load is released does not count.

The disconnect level sits above the pack's per-cell undervoltage cutoff (10.0 V for four cells). The load is therefore shed while charge is still held in reserve. The defaults are:

- disconnect below 11500 mV;
- reconnect above 12500 mV together with more than 20 % charge.

The connected state is also reported in bit 6 of an 8-bit status byte, which a telemetry neighbour decodes.

Top module: `lvd_load_guard`

## Requirements
- R1: While `rst` is high and after it falls, `relay_en` and `trip_flag` are 0 and `stat_byte` is 0x00 until the first strobed sample.
- R2: On the first strobe after reset, `pack_mv` >= 11500 makes `relay_en` 1. A lower value makes `trip_flag` 1 with `relay_en` 0.
- R3: While connected, a strobe with `pack_mv` < 11500 clears `relay_en` and sets `trip_flag` on the clock edge that captures that strobe. This is one clock, far inside the 100 ms limit. A strobe at exactly 11500 leaves the load connected.
- R4: While tripped, the load reconnects only on a strobe where `pack_mv` > 12500 and `soc_pct` > 20 hold together. If only one of the two holds, the block stays tripped.
- R5: The boundary values `pack_mv` = 12500 or `soc_pct` = 20 do not reconnect.
- R6: Without a strobe, `relay_en` and `trip_flag` keep their values whatever `pack_mv` and `soc_pct` show.
- R7: `stat_byte` bit 6 equals `relay_en`. All other bits of `stat_byte` are 0.
- R8: `relay_en` and `trip_flag` are never 1 together. While connected, any strobed voltage from 11500 to 12500 keeps the load connected.
- R9: Asserting `rst` from either the connected or the tripped state returns the block to the R1 state on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample |
| pack_mv | input | 16 | Pack voltage in millivolts, unsigned |
| soc_pct | input | 7 | State of charge in percent, unsigned |
| relay_en | output | 1 | Load relay drive, 1 = connected |
| trip_flag | output | 1 | 1 while latched off by low voltage |
| stat_byte | output | 8 | Status byte, bit 6 = load connected |

## Verification
The whole internal state is three encodings, and each one shows directly on `relay_en` and `trip_flag` one clock after the strobe that caused it. A wrong state therefore shows at the ports on the very next sample. An errant reconnect shows up as `relay_en` rising after a strobe that met only one of the two reconnect conditions. A lost latch shows up as `trip_flag` falling on a voltage-only recovery. Any sensitivity to unstrobed inputs shows up as an output change on a cycle with `smp_stb` low.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LIVE = 2'd1,
        ST_SHED = 2'd2
    } guard_st_e;

    typedef struct packed {
        logic below_cut;
        logic above_rejoin;
        logic soc_ok;
    } cmp_flags_t;

    localparam int STAT_W        = 8;
    localparam int STAT_CONN_BIT = 6;

    function automatic guard_st_e next_state(guard_st_e cur, cmp_flags_t f);
        guard_st_e n;
        n = cur;
        case (cur)
            ST_WAIT: n = f.below_cut ? ST_SHED : ST_LIVE;
            ST_LIVE: if (f.below_cut) n = ST_SHED;
            ST_SHED: if (f.above_rejoin && f.soc_ok) n = ST_LIVE;
            default: n = ST_WAIT;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lvd_cmp.sv
module lvd_cmp
    import lvd_pkg::*;
#(
    parameter int V_W       = 16,
    parameter int S_W       = 7,
    parameter int CUT_MV    = 11500,
    parameter int REJOIN_MV = 12500,
    parameter int SOC_MIN   = 20
) (
    input  logic [V_W-1:0] mv,
    input  logic [S_W-1:0] soc,
    output cmp_flags_t     flags
);
    localparam logic [V_W-1:0] CUT_C    = V_W'(CUT_MV);
    localparam logic [V_W-1:0] REJOIN_C = V_W'(REJOIN_MV);
    localparam logic [S_W-1:0] SOC_C    = S_W'(SOC_MIN);

    always_comb begin
        flags.below_cut    = (mv < CUT_C);
        flags.above_rejoin = (mv > REJOIN_C);
        flags.soc_ok       = (soc > SOC_C);
    end
endmodule

// File: rtl/lvd_fsm.sv
module lvd_fsm
    import lvd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  cmp_flags_t flags,
    output guard_st_e  st
);
    guard_st_e nxt;

    always_comb nxt = next_state(st, flags);

    always_ff @(posedge clk) begin
        if (rst)      st <= ST_WAIT;
        else if (stb) st <= nxt;
    end
endmodule

// File: rtl/lvd_load_guard.sv
module lvd_load_guard
    import lvd_pkg::*;
#(
    parameter int V_W       = 16,
    parameter int S_W       = 7,
    parameter int CUT_MV    = 11500,
    parameter int REJOIN_MV = 12500,
    parameter int SOC_MIN   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [V_W-1:0]    pack_mv,
    input  logic [S_W-1:0]    soc_pct,
    output logic              relay_en,
    output logic              trip_flag,
    output logic [STAT_W-1:0] stat_byte
);
    cmp_flags_t flags;
    guard_st_e  st;

    lvd_cmp #(
        .V_W(V_W), .S_W(S_W), .CUT_MV(CUT_MV),
        .REJOIN_MV(REJOIN_MV), .SOC_MIN(SOC_MIN)
    ) u_cmp (
        .mv(pack_mv), .soc(soc_pct), .flags(flags)
    );

    lvd_fsm u_fsm (
        .clk(clk), .rst(rst), .stb(smp_stb), .flags(flags), .st(st)
    );

    assign relay_en  = (st == ST_LIVE);
    assign trip_flag = (st == ST_SHED);

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == STAT_CONN_BIT) begin : g_conn
            assign stat_byte[b] = relay_en;
        end else begin : g_zero
            assign stat_byte[b] = 1'b0;
        end
    end

    localparam logic [V_W-1:0] CUT_A    = V_W'(CUT_MV);
    localparam logic [V_W-1:0] REJOIN_A = V_W'(REJOIN_MV);
    localparam logic [S_W-1:0] SOC_A    = S_W'(SOC_MIN);

    // R1, R9: reset always lands in the idle state
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!relay_en && !trip_flag));

    // R3: a low strobe while connected sheds the load on the next clock
    p_shed_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (relay_en && smp_stb && pack_mv < CUT_A) |=> (!relay_en && trip_flag));

    // R4: a tripped block stays tripped unless both conditions hold together
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (trip_flag && smp_stb && !(pack_mv > REJOIN_A && soc_pct > SOC_A))
        |=> trip_flag);

    // R4: both conditions together reconnect
    p_rejoin_r4: assert property (@(posedge clk) disable iff (rst)
        (trip_flag && smp_stb && pack_mv > REJOIN_A && soc_pct > SOC_A)
        |=> relay_en);

    // R6: nothing moves without a strobe
    p_no_stb_r6: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(relay_en) && $stable(trip_flag)));

    // R8: the two indications are mutually exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(relay_en && trip_flag));
endmodule

// File: tb/lvd_load_guard_tb.sv
module lvd_load_guard_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_stb;
    logic [15:0] pack_mv;
    logic [6:0]  soc_pct;
    logic        relay_en;
    logic        trip_flag;
    logic [7:0]  stat_byte;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lvd_load_guard u_dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .pack_mv(pack_mv),
        .soc_pct(soc_pct), .relay_en(relay_en), .trip_flag(trip_flag),
        .stat_byte(stat_byte)
    );

    task automatic chk(string req, logic r_exp, logic t_exp);
        logic [7:0] s_exp;
        s_exp = {1'b0, r_exp, 6'b0};
        n_vec++;
        if (relay_en !== r_exp || trip_flag !== t_exp || stat_byte !== s_exp) begin
            n_bad++;
            $display("FAIL %s: relay=%b trip=%b stat=%h expected relay=%b trip=%b stat=%h",
                     req, relay_en, trip_flag, stat_byte, r_exp, t_exp, s_exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_stb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sample(int mv, int soc);
        @(negedge clk);
        pack_mv = 16'(mv); soc_pct = 7'(soc); smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; smp_stb = 1'b0;
        @(negedge clk);
        chk("R1 during reset", 1'b0, 1'b0);
        rst = 1'b0; pack_mv = 16'd13000; soc_pct = 7'd90;
        repeat (3) @(negedge clk);
        chk("R1 idle before first strobe", 1'b0, 1'b0);
    endtask

    task automatic t_start();
        do_reset(); sample(11500, 50);
        chk("R2 first sample at cut level connects", 1'b1, 1'b0);
        do_reset(); sample(11499, 90);
        chk("R2 first sample below cut trips", 1'b0, 1'b1);
    endtask

    task automatic t_shed();
        do_reset(); sample(13000, 60);
        sample(11500, 60);
        chk("R3 exactly cut level keeps load", 1'b1, 1'b0);
        @(negedge clk);
        pack_mv = 16'd11000; smp_stb = 1'b1;
        @(posedge clk); #1;
        chk("R3 shed on capturing edge", 1'b0, 1'b1);
        @(negedge clk); smp_stb = 1'b0;
    endtask

    task automatic t_rejoin();
        sample(14000, 15);
        chk("R4 voltage alone does not reconnect", 1'b0, 1'b1);
        sample(12000, 95);
        chk("R4 charge alone does not reconnect", 1'b0, 1'b1);
        sample(12500, 95);
        chk("R5 voltage at reconnect level holds trip", 1'b0, 1'b1);
        sample(13500, 20);
        chk("R5 charge at minimum holds trip", 1'b0, 1'b1);
        sample(12501, 21);
        chk("R4 both conditions reconnect", 1'b1, 1'b0);
    endtask

    task automatic t_no_stb();
        @(negedge clk); pack_mv = 16'd9000; soc_pct = 7'd0;
        repeat (4) @(negedge clk);
        chk("R6 unstrobed low voltage ignored", 1'b1, 1'b0);
        sample(11000, 0);
        @(negedge clk); pack_mv = 16'd15000; soc_pct = 7'd100;
        repeat (4) @(negedge clk);
        chk("R6 unstrobed recovery ignored", 1'b0, 1'b1);
    endtask

    task automatic t_hyst();
        do_reset(); sample(12800, 50);
        for (int mv = 11500; mv <= 12500; mv += 250) begin
            sample(mv, 5);
            chk("R8 hysteresis band keeps load", 1'b1, 1'b0);
        end
        chk("R7 status bit 6 tracks relay", 1'b1, 1'b0);
    endtask

    task automatic t_rst_mid();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 reset from connected", 1'b0, 1'b0);
        sample(10000, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 reset from tripped", 1'b0, 1'b0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_stb = 1'b0; pack_mv = '0; soc_pct = '0;
        t_reset();
        t_start();
        t_shed();
        t_rejoin();
        t_no_stb();
        t_hyst();
        t_rst_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule